// File: doc/BRIEF.md
# DMA Global Operation Control Register

This block is the global operation register of a multi-channel DMA controller. It is an 8-bit register with three live bits. The first is a master enable that the CPU can read and write. The second and third are two sticky error flags: one is set by an NMI event and the other by an address-error event. The flags cannot be set from software. They can be cleared only by a guarded sequence: the CPU reads the flag as 1, and then its next write to the register carries a 0 in that bit. The register combines the flags, the master enable and each channel's enable (DE) and end (TE) status bits into a registered vector of per-channel transfer permits. It also drives a global suspend indication and an address-error interrupt level.

Each flag is a three-state machine with these states and transitions:

- **FLG_CLEAR**: the flag reads 0.
  - *raise*: a set event moves it to FLG_SET.
- **FLG_SET**: the flag reads 1 and clearing is not yet allowed.
  - *arm*: a register read without a write in the same cycle moves it to FLG_ARMED.
  - *hold*: any other cycle leaves it in FLG_SET.
- **FLG_ARMED**: the flag reads 1 and a clearing write is allowed.
  - *clear*: a write with 0 in the flag bit and no set event moves it to FLG_CLEAR.
  - *disarm*: a write with 1 in the flag bit, or any write that meets a set event, moves it back to FLG_SET.
  - *wait*: a cycle with no write leaves it in FLG_ARMED.

Top module: `dmag_ctrl`

## Requirements
- R1: After reset the register reads 0x00, every permit bit is 0, the interrupt is 0 and the suspend indication is 1. A reset also clears flags that were set.
- R2: Read data places the master enable at bit 0, the NMI flag at bit 1 and the address-error flag at bit 2. Bits 7 to 3 always read 0, even after a write of 1s to them.
- R3: A CPU write stores data bit 0 into the master enable, and the next read returns the stored value.
- R4: A pulse on the address-error event sets bit 2. A CPU write of 1 to bit 1 or to bit 2 never sets a flag that is clear.
- R5: A flag clears only when a write with 0 in its bit follows a read that returned it as 1. A write of 0 with no such earlier read leaves the flag at 1.
- R6: The armed condition is used up by the next write to the register. If that write carries a 1 in the flag bit, the flag stays set and a later write of 0 needs a new read first. Each flag is armed and cleared on its own.
- R7: If a set event and a clearing write reach a flag in the same cycle, the flag stays 1.
- R8: A pulse on the NMI event sets bit 1 whether the master enable is 0 or 1. The NMI flag clears by the same read-then-write-0 rule as the address-error flag.
- R9: The address-error interrupt output is a level equal to the address-error flag.
- R10: Permit bit i is registered. After a clock edge it equals master-enable AND DE[i] AND NOT TE[i] AND NOT NMI flag AND NOT address-error flag, with all of these taken as they stood just before that edge.
- R11: The suspend output equals (NOT master enable) OR NMI flag OR address-error flag, taken from the current register contents.
- R12: A read strobe in the same cycle as a write strobe does not arm either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_rd | input | 1 | Register read strobe |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Current register contents |
| addr_err_evt | input | 1 | Address-error event pulse |
| nmi_evt | input | 1 | NMI event pulse |
| ch_de | input | N_CH | Per-channel enable bits |
| ch_te | input | N_CH | Per-channel transfer-end bits |
| ch_permit | output | N_CH | Registered per-channel transfer permit |
| suspend_all | output | 1 | All channels suspended |
| addr_err_irq | output | 1 | Address-error interrupt level |

## Verification
The bench builds the block with N_CH = 4. Four channels are enough to drive DE and TE patterns that differ channel by channel, so a permit vector mixes granted and withheld channels in one cycle. That shows the per-channel gating is separate from the global gate. With this width the bench can also drive every channel's TE high at once while the global gate stays open.

// File: rtl/dmag_pkg.sv
package dmag_pkg;
    localparam int unsigned REG_W   = 8;
    localparam int unsigned BIT_ME  = 0;
    localparam int unsigned BIT_NMI = 1;
    localparam int unsigned BIT_AE  = 2;
    localparam int unsigned RSV_LO  = 3;

    typedef enum logic [1:0] {
        FLG_CLEAR = 2'd0,
        FLG_SET   = 2'd1,
        FLG_ARMED = 2'd2
    } flag_state_e;
endpackage

// File: rtl/dmag_flag_fsm.sv
module dmag_flag_fsm
    import dmag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic rd_en,
    input  logic wr_en,
    input  logic wr_bit,
    output logic flag_o
);
    flag_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_CLEAR;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_CLEAR: begin
                if (set_evt) state_d = FLG_SET;                 // raise
            end
            FLG_SET: begin
                if (rd_en && !wr_en) state_d = FLG_ARMED;       // arm
            end
            FLG_ARMED: begin
                if (wr_en) begin
                    if (set_evt || wr_bit) state_d = FLG_SET;   // disarm
                    else                   state_d = FLG_CLEAR; // clear
                end
            end
            default: state_d = FLG_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        flag_o = (state_q != FLG_CLEAR);
    end

    // R4: software alone never raises a clear flag
    p_no_cpu_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FLG_CLEAR && !set_evt) |=> (state_q == FLG_CLEAR));

    // R5: a flag that has not been read as 1 cannot be cleared
    p_clear_needs_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FLG_SET) |=> (state_q != FLG_CLEAR));

    // R7: a set event always leaves the flag at 1
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag_o);

    // R12: a read that meets a write does not arm
    p_no_arm_on_rw_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FLG_SET && rd_en && wr_en) |=> (state_q == FLG_SET));
endmodule

// File: rtl/dmag_permit.sv
module dmag_permit #(
    parameter int unsigned N_CH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            me,
    input  logic            nmi_flag,
    input  logic            ae_flag,
    input  logic [N_CH-1:0] de,
    input  logic [N_CH-1:0] te,
    output logic [N_CH-1:0] permit_o
);
    logic global_ok;
    assign global_ok = me && !nmi_flag && !ae_flag;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) permit_o[g] <= 1'b0;
            else        permit_o[g] <= global_ok && de[g] && !te[g];
        end

        // R10: a finished channel is never granted on the next cycle
        p_te_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
            te[g] |=> !permit_o[g]);
    end

    // R10: any global stop condition withdraws all permits on the next cycle
    p_global_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!me || nmi_flag || ae_flag) |=> (permit_o == '0));
endmodule

// File: rtl/dmag_ctrl.sv
module dmag_ctrl
    import dmag_pkg::*;
#(
    parameter int unsigned N_CH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_rd,
    input  logic             cpu_wr,
    input  logic [REG_W-1:0] cpu_wdata,
    output logic [REG_W-1:0] cpu_rdata,
    input  logic             addr_err_evt,
    input  logic             nmi_evt,
    input  logic [N_CH-1:0]  ch_de,
    input  logic [N_CH-1:0]  ch_te,
    output logic [N_CH-1:0]  ch_permit,
    output logic             suspend_all,
    output logic             addr_err_irq
);
    logic me_q;
    logic nmi_flag;
    logic ae_flag;
    logic unused_rsvd;

    assign unused_rsvd = ^cpu_wdata[REG_W-1:RSV_LO];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      me_q <= 1'b0;
        else if (cpu_wr) me_q <= cpu_wdata[BIT_ME];
    end

    dmag_flag_fsm u_nmi_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (nmi_evt),
        .rd_en   (cpu_rd),
        .wr_en   (cpu_wr),
        .wr_bit  (cpu_wdata[BIT_NMI]),
        .flag_o  (nmi_flag)
    );

    dmag_flag_fsm u_ae_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (addr_err_evt),
        .rd_en   (cpu_rd),
        .wr_en   (cpu_wr),
        .wr_bit  (cpu_wdata[BIT_AE]),
        .flag_o  (ae_flag)
    );

    dmag_permit #(.N_CH(N_CH)) u_permit (
        .clk      (clk),
        .rst_n    (rst_n),
        .me       (me_q),
        .nmi_flag (nmi_flag),
        .ae_flag  (ae_flag),
        .de       (ch_de),
        .te       (ch_te),
        .permit_o (ch_permit)
    );

    always_comb begin
        cpu_rdata          = '0;
        cpu_rdata[BIT_ME]  = me_q;
        cpu_rdata[BIT_NMI] = nmi_flag;
        cpu_rdata[BIT_AE]  = ae_flag;
    end

    assign suspend_all  = !me_q || nmi_flag || ae_flag;
    assign addr_err_irq = ae_flag;

    // R9: an address-error event raises the interrupt on the next cycle
    p_irq_follows_evt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err_evt |=> addr_err_irq);

    // R3: the master enable takes the written value
    p_me_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr |=> (cpu_rdata[BIT_ME] == $past(cpu_wdata[BIT_ME])));

    // R11: while suspended, no channel holds a permit one cycle later
    p_suspend_no_permit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_all |=> (ch_permit == '0));
endmodule

// File: tb/dmag_ctrl_tb.sv
`timescale 1ns/1ps
module dmag_ctrl_tb;
    localparam int N_CH = 4;

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic       ae;
        logic       nmi;
        logic [7:0] data;
        logic [3:0] de;
        logic [3:0] te;
        logic [7:0] exp_reg;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,1'b0,1'b0,8'h01,4'hF,4'h0,8'h01}, // 0  R3 enable on
        '{1'b0,1'b0,1'b0,1'b0,8'h00,4'hF,4'h0,8'h01}, // 1  R10 all permitted
        '{1'b1,1'b0,1'b0,1'b0,8'hFF,4'hF,4'h0,8'h01}, // 2  R2 R4 no sw set, reserved 0
        '{1'b0,1'b0,1'b0,1'b0,8'h00,4'h5,4'h1,8'h01}, // 3  R10 mixed
        '{1'b0,1'b0,1'b1,1'b0,8'h00,4'hF,4'h0,8'h05}, // 4  R4 R9 address error
        '{1'b0,1'b0,1'b0,1'b0,8'h00,4'hF,4'h0,8'h05}, // 5  R10 R11 suspended
        '{1'b1,1'b0,1'b0,1'b0,8'h01,4'hF,4'h0,8'h05}, // 6  R5 write 0 unread
        '{1'b0,1'b1,1'b0,1'b0,8'h00,4'hF,4'h0,8'h05}, // 7  arm
        '{1'b1,1'b0,1'b0,1'b0,8'h05,4'hF,4'h0,8'h05}, // 8  R6 write 1 uses arm
        '{1'b1,1'b0,1'b0,1'b0,8'h01,4'hF,4'h0,8'h05}, // 9  R6 still set
        '{1'b0,1'b1,1'b0,1'b0,8'h00,4'hF,4'h0,8'h05}, // 10 arm
        '{1'b1,1'b0,1'b0,1'b0,8'h01,4'hF,4'h0,8'h01}, // 11 R5 cleared
        '{1'b0,1'b0,1'b0,1'b1,8'h00,4'hF,4'h0,8'h03}, // 12 R8 NMI
        '{1'b0,1'b1,1'b0,1'b0,8'h00,4'hF,4'h0,8'h03}, // 13 arm
        '{1'b1,1'b0,1'b0,1'b1,8'h01,4'hF,4'h0,8'h03}, // 14 R7 set wins
        '{1'b1,1'b1,1'b0,1'b0,8'h01,4'hF,4'h0,8'h03}, // 15 R12 rd+wr
        '{1'b1,1'b0,1'b0,1'b0,8'h01,4'hF,4'h0,8'h03}, // 16 R12 not armed
        '{1'b0,1'b1,1'b0,1'b0,8'h00,4'hF,4'h0,8'h03}, // 17 arm
        '{1'b1,1'b0,1'b0,1'b0,8'h00,4'hF,4'h0,8'h00}, // 18 R8 clear, enable off
        '{1'b0,1'b0,1'b0,1'b1,8'h00,4'hF,4'h0,8'h02}, // 19 R8 NMI while disabled
        '{1'b0,1'b1,1'b0,1'b0,8'h00,4'hF,4'h0,8'h02}, // 20 arm
        '{1'b1,1'b0,1'b0,1'b0,8'h00,4'hF,4'h0,8'h00}, // 21 R8 clear
        '{1'b1,1'b0,1'b0,1'b0,8'h01,4'hF,4'h0,8'h01}, // 22 R3
        '{1'b0,1'b0,1'b1,1'b1,8'h00,4'hF,4'h0,8'h07}, // 23 both flags
        '{1'b0,1'b1,1'b0,1'b0,8'h00,4'hF,4'h0,8'h07}, // 24 arm both
        '{1'b1,1'b0,1'b0,1'b0,8'h03,4'hF,4'h0,8'h03}, // 25 R6 per-flag
        '{1'b0,1'b1,1'b0,1'b0,8'h00,4'hF,4'h0,8'h03}, // 26 arm
        '{1'b1,1'b0,1'b0,1'b0,8'h01,4'hF,4'h0,8'h01}, // 27 R5
        '{1'b0,1'b0,1'b0,1'b0,8'h00,4'hA,4'h2,8'h01}, // 28 R10 mixed
        '{1'b0,1'b0,1'b0,1'b0,8'h00,4'hF,4'hF,8'h01}  // 29 R10 all ended
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cpu_rd = 1'b0;
    logic            cpu_wr = 1'b0;
    logic [7:0]      cpu_wdata = '0;
    logic [7:0]      cpu_rdata;
    logic            addr_err_evt = 1'b0;
    logic            nmi_evt = 1'b0;
    logic [N_CH-1:0] ch_de = '0;
    logic [N_CH-1:0] ch_te = '0;
    logic [N_CH-1:0] ch_permit;
    logic            suspend_all;
    logic            addr_err_irq;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dmag_ctrl #(.N_CH(N_CH)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_rd       (cpu_rd),
        .cpu_wr       (cpu_wr),
        .cpu_wdata    (cpu_wdata),
        .cpu_rdata    (cpu_rdata),
        .addr_err_evt (addr_err_evt),
        .nmi_evt      (nmi_evt),
        .ch_de        (ch_de),
        .ch_te        (ch_te),
        .ch_permit    (ch_permit),
        .suspend_all  (suspend_all),
        .addr_err_irq (addr_err_irq)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
        end
    endtask

    task automatic check_reset_state(input string tag);
        check({tag, " register"}, 32'(cpu_rdata), 32'h00);
        check({tag, " permit"}, 32'(ch_permit), 32'h0);
        check({tag, " irq"}, 32'(addr_err_irq), 32'h0);
        check({tag, " suspend"}, 32'(suspend_all), 32'h1);
    endtask

    initial begin : watchdog
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks + 1, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] prev_reg;
        logic [3:0] exp_permit;
        logic       gate;
        repeat (3) @(negedge clk);
        check_reset_state("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);

        prev_reg = 8'h00;
        for (int i = 0; i < NV; i++) begin
            cpu_wr       = VECS[i].wr;
            cpu_rd       = VECS[i].rd;
            addr_err_evt = VECS[i].ae;
            nmi_evt      = VECS[i].nmi;
            cpu_wdata    = VECS[i].data;
            ch_de        = VECS[i].de;
            ch_te        = VECS[i].te;
            @(posedge clk);
            @(negedge clk);
            // R2 R3 R4 R5 R6 R7 R8 R12: register contents
            check($sformatf("R2-layout/flag rules vec %0d register", i),
                  32'(cpu_rdata), 32'(VECS[i].exp_reg));
            // R10: permit from the state before this edge and this cycle's DE/TE
            gate = prev_reg[0] && !prev_reg[1] && !prev_reg[2];
            exp_permit = gate ? (VECS[i].de & ~VECS[i].te) : 4'h0;
            check($sformatf("R10 vec %0d permit", i), 32'(ch_permit), 32'(exp_permit));
            // R11
            check($sformatf("R11 vec %0d suspend", i), 32'(suspend_all),
                  32'(!VECS[i].exp_reg[0] || VECS[i].exp_reg[1] || VECS[i].exp_reg[2]));
            // R9
            check($sformatf("R9 vec %0d irq", i), 32'(addr_err_irq), 32'(VECS[i].exp_reg[2]));
            prev_reg = VECS[i].exp_reg;
        end

        // R1: reset in the middle of operation clears set flags
        cpu_wr = 1'b0; cpu_rd = 1'b0; nmi_evt = 1'b0;
        addr_err_evt = 1'b1;
        @(posedge clk);
        @(negedge clk);
        addr_err_evt = 1'b0;
        check("R1 pre-reset flag set", 32'(cpu_rdata), 32'h05);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state("R1 mid-run reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R4: a write of 1 to both flags from a clear state sets neither
        cpu_wr = 1'b1; cpu_wdata = 8'h06;
        @(posedge clk);
        @(negedge clk);
        cpu_wr = 1'b0;
        check("R4 write-1 from clear", 32'(cpu_rdata), 32'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule